// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block sits on the host side of a three-wire link to a 10-bit successive-approximation ADC. It drives the converter's active-low select, its serial clock and its active-low power-down pin, and it samples the converter's serial data line. Each request runs one conversion. The controller lowers select, produces a burst of serial clock pulses from the system clock, and shifts in the returned bits. It then discards the zero padding and hands the 10-bit result and the two sub-bits to the core as a parallel word with a one-cycle strobe.

The serial clock runs with idle-low polarity. The controller samples data on each rising edge, and the converter moves its data line shortly after each rising edge. Rising edge number k therefore captures the bit the converter placed after edge k-1. The first three samples are always zero. A mode input picks one of two transfer lengths. The 16-clock form yields two full bytes, with the result in samples 4 to 13, the sub-bits in samples 14 and 15, and a zero in sample 16. The 13-clock form stops as soon as the last result bit is in.

Between conversions the controller keeps select high for a minimum number of cycles. After an early abort it waits a longer acquisition interval. When power-down is released, it waits a programmable number of cycles before any conversion may start.

Top module: `adcReadCtl`

## Requirements
- R1: While reset is held and in the first cycle after it, adcCsN is 1, adcSclk is 0, adcShdnN is 0 (power-down asserted), resValid is 0 and idle is 0.
- R2: While shdnReq is 1 and the controller is not converting, adcShdnN goes to 0 on the next clock and start requests are ignored (adcCsN stays 1). After shdnReq returns to 0, adcShdnN goes to 1, and adcCsN stays 1 for at least wakeCycles clock cycles after that.
- R3: adcSclk is 0 in every cycle in which adcCsN is 1, including the cycle in which adcCsN falls.
- R4: Every high phase of adcSclk and every low phase between pulses, including the first low phase after adcCsN falls, lasts H system clock cycles, where H = max(halfDiv, MIN_HALF) and MIN_HALF defaults to 8.
- R5: With shortMode = 0 a transfer issues exactly 16 rising edges of adcSclk. resData takes samples 4 to 13 with sample 4 as bit 9, and resSub takes samples 14 and 15 with sample 14 as bit 1.
- R6: With shortMode = 1 a transfer issues exactly 13 rising edges. resData takes samples 4 to 13 with sample 4 as bit 9, and resSub is 0.
- R7: resValid is high for exactly one cycle per completed transfer. It rises on the same clock edge on which adcCsN returns to 1 and adcSclk falls after the last high phase.
- R8: After a completed transfer, adcCsN stays high for at least CS_HIGH_CYC cycles (default 6) before it falls again.
- R9: An abortReq of 1 during a transfer sets adcCsN to 1 and adcSclk to 0 on the next clock and produces no resValid. It holds idle at 0, and adcCsN at 1, for at least ACQ_CYC cycles (default 40).
- R10: A start request is taken only while idle is 1 and shdnReq is 0. A start request during a transfer or a wait changes neither the current transfer nor the number of transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request one conversion (taken only when idle) |
| abortReq | input | 1 | End the current transfer early |
| shdnReq | input | 1 | Request converter power-down |
| shortMode | input | 1 | 1 selects the 13-clock read, 0 the 16-clock read |
| halfDiv | input | 8 | Serial clock half period in system cycles (raised to MIN_HALF if smaller) |
| wakeCycles | input | 18 | Wake-up wait after power-down release, in system cycles |
| adcDout | input | 1 | Serial data from the converter |
| adcCsN | output | 1 | Converter select, active low |
| adcSclk | output | 1 | Serial clock to the converter |
| adcShdnN | output | 1 | Converter power-down, active low |
| idle | output | 1 | Controller ready for a start request |
| resValid | output | 1 | One-cycle strobe marking a new result |
| resData | output | 10 | Conversion result |
| resSub | output | 2 | Sub-bits of the conversion (0 in short mode) |

## Verification
On every cycle, the assertions check the following: the serial clock stays low whenever select is high, select stays high during power-down, and an abort releases select and the clock on the next edge. They also check the minimum select-high gap and that the result strobe never lasts two cycles. Other behaviours need a modelled converter on the data line, so only the bench scenarios can show them. These are the bit alignment of the result and sub-bits, the rising-edge count of each mode, the half-period lengths with a clamped divider, and the wake-up and acquisition waits. The bench also shows that start requests are ignored while busy or powered down.

// File: rtl/adcReadPkg.sv
package adcReadPkg;

  typedef enum logic [2:0] {
    ST_SHUT,
    ST_WAKE,
    ST_IDLE,
    ST_SETUP,
    ST_HIGH,
    ST_LOW,
    ST_GAP,
    ST_ACQ
  } ctlState_t;

  typedef struct packed {
    logic clear;
    logic shift;
    logic finish;
    logic shortSel;
  } pathStrobe_t;

endpackage

// File: rtl/adcReadCtrl.sv
module adcReadCtrl
  import adcReadPkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int SUB_W      = 2,
  parameter int LEAD_ZEROS = 3,
  parameter int MIN_HALF   = 8,
  parameter int DIV_W      = 8,
  parameter int WAKE_W     = 18,
  parameter int CS_HIGH_CYC = 6,
  parameter int ACQ_CYC    = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              abortReq,
  input  logic              shdnReq,
  input  logic              shortMode,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic [WAKE_W-1:0] wakeCycles,
  output logic              csN,
  output logic              sclk,
  output logic              shdnN,
  output logic              idle,
  output pathStrobe_t       strobe
);

  localparam int SHORT_CLKS = LEAD_ZEROS + DATA_W;
  localparam int BYTE_CLKS  = LEAD_ZEROS + DATA_W + SUB_W + 1;
  localparam int BIT_W      = $clog2(BYTE_CLKS + 1);

  ctlState_t         state, nextState;
  logic [DIV_W-1:0]  halfCnt, halfLat, halfEff;
  logic [BIT_W-1:0]  bitCnt, lastClk;
  logic [WAKE_W-1:0] waitCnt;
  logic              shortLat;
  logic              inXfer, abortHit;
  logic [7:0]        gapSeen;

  assign halfEff  = (halfDiv < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : halfDiv;
  assign lastClk  = shortLat ? BIT_W'(SHORT_CLKS) : BIT_W'(BYTE_CLKS);
  assign inXfer   = (state == ST_SETUP) || (state == ST_HIGH) || (state == ST_LOW);
  assign abortHit = inXfer && abortReq;

  always_comb begin
    nextState       = state;
    strobe.clear    = 1'b0;
    strobe.shift    = 1'b0;
    strobe.finish   = 1'b0;
    strobe.shortSel = shortLat;
    unique case (state)
      ST_SHUT:  if (!shdnReq) nextState = ST_WAKE;
      ST_WAKE: begin
        if (shdnReq)            nextState = ST_SHUT;
        else if (waitCnt == '0) nextState = ST_IDLE;
      end
      ST_IDLE: begin
        if (shdnReq) nextState = ST_SHUT;
        else if (startReq) begin
          nextState    = ST_SETUP;
          strobe.clear = 1'b1;
        end
      end
      ST_SETUP, ST_LOW: begin
        if (abortHit) nextState = ST_ACQ;
        else if (halfCnt == '0) begin
          nextState    = ST_HIGH;
          strobe.shift = 1'b1;
        end
      end
      ST_HIGH: begin
        if (abortHit) nextState = ST_ACQ;
        else if (halfCnt == '0) begin
          if (bitCnt == lastClk) begin
            nextState     = ST_GAP;
            strobe.finish = 1'b1;
          end else begin
            nextState = ST_LOW;
          end
        end
      end
      ST_GAP, ST_ACQ: if (waitCnt == '0) nextState = ST_IDLE;
      default: nextState = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_SHUT;
      halfCnt  <= '0;
      halfLat  <= DIV_W'(MIN_HALF);
      bitCnt   <= '0;
      waitCnt  <= '0;
      shortLat <= 1'b0;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      shdnN    <= 1'b0;
      idle     <= 1'b0;
    end else begin
      state <= nextState;
      csN   <= !((nextState == ST_SETUP) || (nextState == ST_HIGH) || (nextState == ST_LOW));
      sclk  <= (nextState == ST_HIGH);
      shdnN <= (nextState != ST_SHUT);
      idle  <= (nextState == ST_IDLE);

      if (state == ST_IDLE && nextState == ST_SETUP) begin
        halfLat  <= halfEff;
        shortLat <= shortMode;
        halfCnt  <= halfEff - 1'b1;
        bitCnt   <= '0;
      end else if (nextState != state) begin
        halfCnt <= halfLat - 1'b1;
        if (nextState == ST_HIGH) bitCnt <= bitCnt + 1'b1;
      end else if (halfCnt != '0) begin
        halfCnt <= halfCnt - 1'b1;
      end

      if (state == ST_SHUT && nextState == ST_WAKE)      waitCnt <= wakeCycles;
      else if (nextState == ST_GAP && state != ST_GAP)   waitCnt <= WAKE_W'(CS_HIGH_CYC - 1);
      else if (nextState == ST_ACQ && state != ST_ACQ)   waitCnt <= WAKE_W'(ACQ_CYC - 1);
      else if (waitCnt != '0)                            waitCnt <= waitCnt - 1'b1;
    end
  end

  // Cycles select has been high, saturating; used by the gap check below.
  always_ff @(posedge clk) begin
    if (!rstN)                        gapSeen <= '0;
    else if (!csN)                    gapSeen <= '0;
    else if (gapSeen != 8'hFF)        gapSeen <= gapSeen + 1'b1;
  end

  assert_sclk_low_deselected_R3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  assert_no_select_in_shutdown_R2: assert property (@(posedge clk) disable iff (!rstN)
    !shdnN |-> csN);

  assert_abort_release_R9: assert property (@(posedge clk) disable iff (!rstN)
    abortHit |=> (csN && !sclk && state == ST_ACQ));

  assert_min_select_gap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (csN && nextState == ST_SETUP) |-> (int'(gapSeen) >= CS_HIGH_CYC));

endmodule

// File: rtl/adcReadPath.sv
module adcReadPath
  import adcReadPkg::*;
#(
  parameter int DATA_W     = 10,
  parameter int SUB_W      = 2,
  parameter int LEAD_ZEROS = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  pathStrobe_t       strobe,
  input  logic              adcDout,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [SUB_W-1:0]  resSub
);

  localparam int SHIFT_W = LEAD_ZEROS + DATA_W + SUB_W + 1;

  logic [SHIFT_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      resValid <= 1'b0;
      resData  <= '0;
      resSub   <= '0;
    end else begin
      resValid <= strobe.finish;
      if (strobe.clear)      shiftReg <= '0;
      else if (strobe.shift) shiftReg <= {shiftReg[SHIFT_W-2:0], adcDout};
      if (strobe.finish) begin
        if (strobe.shortSel) begin
          resData <= shiftReg[0 +: DATA_W];
          resSub  <= '0;
        end else begin
          resData <= shiftReg[SUB_W + 1 +: DATA_W];
          resSub  <= shiftReg[1 +: SUB_W];
        end
      end
    end
  end

  assert_valid_single_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.clear, strobe.shift, strobe.finish}) <= 1);

endmodule

// File: rtl/adcReadCtl.sv
module adcReadCtl
  import adcReadPkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SUB_W       = 2,
  parameter int LEAD_ZEROS  = 3,
  parameter int MIN_HALF    = 8,
  parameter int DIV_W       = 8,
  parameter int WAKE_W      = 18,
  parameter int CS_HIGH_CYC = 6,
  parameter int ACQ_CYC     = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              abortReq,
  input  logic              shdnReq,
  input  logic              shortMode,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic [WAKE_W-1:0] wakeCycles,
  input  logic              adcDout,
  output logic              adcCsN,
  output logic              adcSclk,
  output logic              adcShdnN,
  output logic              idle,
  output logic              resValid,
  output logic [DATA_W-1:0] resData,
  output logic [SUB_W-1:0]  resSub
);

  pathStrobe_t strobe;

  adcReadCtrl #(
    .DATA_W(DATA_W), .SUB_W(SUB_W), .LEAD_ZEROS(LEAD_ZEROS), .MIN_HALF(MIN_HALF),
    .DIV_W(DIV_W), .WAKE_W(WAKE_W), .CS_HIGH_CYC(CS_HIGH_CYC), .ACQ_CYC(ACQ_CYC)
  ) ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .shdnReq(shdnReq), .shortMode(shortMode), .halfDiv(halfDiv),
    .wakeCycles(wakeCycles), .csN(adcCsN), .sclk(adcSclk), .shdnN(adcShdnN),
    .idle(idle), .strobe(strobe)
  );

  adcReadPath #(
    .DATA_W(DATA_W), .SUB_W(SUB_W), .LEAD_ZEROS(LEAD_ZEROS)
  ) path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .adcDout(adcDout),
    .resValid(resValid), .resData(resData), .resSub(resSub)
  );

endmodule

// File: tb/adcReadCtl_test.sv
module adcReadCtl_test;

  localparam int MIN_HALF = 8;
  localparam int CSH      = 6;
  localparam int ACQ      = 40;

  logic        clk = 1'b0;
  logic        rstN, startReq, abortReq, shdnReq, shortMode;
  logic [7:0]  halfDiv;
  logic [17:0] wakeCycles;
  logic        adcDout = 1'b0;
  logic        adcCsN, adcSclk, adcShdnN, idle, resValid;
  logic [9:0]  resData;
  logic [1:0]  resSub;

  int nChecks = 0;
  int nFails  = 0;

  logic [9:0] devCode = '0;
  logic [1:0] devSub  = '0;
  int devRise = 0;
  int expHalf = MIN_HALF;
  int expGapMin = CSH;

  always #5 clk = ~clk;

  adcReadCtl #(.MIN_HALF(MIN_HALF), .CS_HIGH_CYC(CSH), .ACQ_CYC(ACQ)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .abortReq(abortReq),
    .shdnReq(shdnReq), .shortMode(shortMode), .halfDiv(halfDiv),
    .wakeCycles(wakeCycles), .adcDout(adcDout), .adcCsN(adcCsN),
    .adcSclk(adcSclk), .adcShdnN(adcShdnN), .idle(idle),
    .resValid(resValid), .resData(resData), .resSub(resSub)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Bit the converter places on its data line after rising edge k.
  function automatic logic devBit(input int k, input logic [9:0] c, input logic [1:0] s);
    if (k >= 3 && k <= 12) return c[12-k];
    if (k == 13) return s[1];
    if (k == 14) return s[0];
    return 1'b0;
  endfunction

  function automatic int effHalf(input int h);
    return (h < MIN_HALF) ? MIN_HALF : h;
  endfunction

  // Converter model: zero on select fall, new bit 2 ns after each rise.
  always @(negedge adcCsN or posedge adcSclk) begin
    if (adcSclk) begin
      devRise = devRise + 1;
      #2 adcDout = devBit(devRise, devCode, devSub);
    end else begin
      devRise = 0;
      adcDout = 1'b0;
    end
  end

  // Waveform monitor, sampled on the falling system edge.
  int hiRun = 0, loRun = 0, csRun = 0;
  logic prevCs = 1'b1, prevSclk = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (adcCsN) chk(!adcSclk, "R3 sclk low while deselected", adcSclk, 0);
      if (prevCs && !adcCsN) begin
        chk(!adcSclk, "R3 sclk low at select fall", adcSclk, 0);
        chk(csRun >= expGapMin, "R8/R9 select high gap", csRun, expGapMin);
        expGapMin = CSH;
      end
      if (prevSclk && !adcSclk && (!adcCsN || resValid))
        chk(hiRun == expHalf, "R4 high phase length", hiRun, expHalf);
      if (!prevSclk && adcSclk && !prevCs)
        chk(loRun == expHalf, "R4 low phase length", loRun, expHalf);
      hiRun = adcSclk ? hiRun + 1 : 0;
      loRun = (!adcSclk && !adcCsN) ? loRun + 1 : 0;
      csRun = adcCsN ? csRun + 1 : 0;
      prevCs = adcCsN;
      prevSclk = adcSclk;
    end
  end

  task automatic waitIdle();
    while (!idle) @(negedge clk);
  endtask

  task automatic runConv(input bit shrt, input logic [9:0] code, input logic [1:0] sub,
                         input int half, input bit pokeBusy);
    waitIdle();
    devCode = code; devSub = sub; shortMode = shrt; halfDiv = 8'(half);
    expHalf = effHalf(half);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(!idle, "R10 idle low during transfer", idle, 0);
    if (pokeBusy) begin
      repeat (30) @(negedge clk);
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
    end
    while (!resValid) @(negedge clk);
    chk(adcCsN && !adcSclk, "R7 select released with valid", adcCsN, 1);
    chk(resData == code, shrt ? "R6 short data" : "R5 byte data", resData, code);
    chk(resSub == (shrt ? 2'b00 : sub), shrt ? "R6 short sub zero" : "R5 byte sub",
        resSub, shrt ? 0 : sub);
    chk(devRise == (shrt ? 13 : 16), shrt ? "R6 rise count" : "R5 rise count",
        devRise, shrt ? 13 : 16);
    @(negedge clk);
    chk(!resValid, "R7 valid one cycle", resValid, 0);
    if (pokeBusy) begin
      for (int i = 0; i < CSH + 8; i++) begin
        chk(adcCsN, "R10 busy start ignored", adcCsN, 1);
        @(negedge clk);
      end
    end
  endtask

  task automatic runAbort(input int waitCyc);
    bit sawValid = 0;
    int waitIdleCnt = 0;
    waitIdle();
    shortMode = 1'b0; halfDiv = 8'd8; expHalf = 8;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (waitCyc) @(negedge clk);
    expGapMin = ACQ;
    abortReq = 1'b1;
    @(negedge clk);
    abortReq = 1'b0;
    chk(adcCsN && !adcSclk, "R9 abort releases select", {adcCsN, adcSclk}, 2);
    while (!idle) begin
      if (resValid) sawValid = 1;
      chk(adcCsN, "R9 select high during acquisition wait", adcCsN, 1);
      waitIdleCnt++;
      @(negedge clk);
    end
    chk(!sawValid, "R9 no result after abort", sawValid, 0);
    chk(waitIdleCnt >= ACQ, "R9 acquisition wait", waitIdleCnt, ACQ);
  endtask

  task automatic wakeAndMeasure(input int wake, input logic [9:0] code);
    int hiCnt = 0;
    wakeCycles = 18'(wake);
    devCode = code; devSub = 2'b01; shortMode = 1'b0; halfDiv = 8'd8; expHalf = 8;
    shdnReq = 1'b0;
    startReq = 1'b1;
    while (adcCsN) begin
      @(negedge clk);
      if (adcShdnN) hiCnt++;
    end
    startReq = 1'b0;
    chk(hiCnt >= wake, "R2 wake-up wait", hiCnt, wake);
    while (!resValid) @(negedge clk);
    chk(resData == code, "R5 data after wake", resData, code);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4242));
    rstN = 1'b0; startReq = 1'b0; abortReq = 1'b0; shdnReq = 1'b1;
    shortMode = 1'b0; halfDiv = 8'd8; wakeCycles = 18'd50;
    repeat (3) @(negedge clk);
    chk(adcCsN && !adcSclk && !adcShdnN && !resValid && !idle, "R1 state in reset",
        {adcCsN, adcSclk, adcShdnN, resValid, idle}, 16);
    rstN = 1'b1;
    @(negedge clk);
    chk(adcCsN && !adcSclk && !adcShdnN && !resValid && !idle, "R1 state after reset",
        {adcCsN, adcSclk, adcShdnN, resValid, idle}, 16);

    // Start while powered down is ignored.
    startReq = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(adcCsN && !adcShdnN, "R2 start ignored in shutdown", adcCsN, 1);
    end
    startReq = 1'b0;

    wakeAndMeasure(50, 10'h155);

    // Directed corner cases.
    runConv(1'b0, 10'h3FF, 2'b11, 8, 1'b0);
    runConv(1'b0, 10'h000, 2'b00, 8, 1'b0);
    runConv(1'b1, 10'h2AA, 2'b11, 3, 1'b0);
    runConv(1'b0, 10'h201, 2'b10, 11, 1'b1);
    runConv(1'b1, 10'h3FF, 2'b01, 9, 1'b0);

    runAbort(40);
    runConv(1'b0, 10'h0F0, 2'b01, 8, 1'b0);
    runAbort(5);
    runConv(1'b1, 10'h00F, 2'b10, 8, 1'b0);

    // Shutdown from idle, then wake again with a shorter delay.
    waitIdle();
    shdnReq = 1'b1;
    @(negedge clk);
    chk(!adcShdnN && adcCsN, "R2 shutdown on request", adcShdnN, 0);
    startReq = 1'b1;
    repeat (5) @(negedge clk);
    chk(adcCsN, "R2 start ignored after shutdown", adcCsN, 1);
    startReq = 1'b0;
    wakeAndMeasure(20, 10'h3A5);

    // Random conversions.
    for (int n = 0; n < 24; n++) begin
      runConv(1'($urandom), 10'($urandom), 2'($urandom), 2 + int'($urandom % 12), 1'b0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule